// File: doc/BRIEF.md
# Execute-Stage Redirect and Squash Generator

This block looks at the group of instructions that finish execution in one clock, oldest in slot 0 and youngest in the last slot. For every hardware thread it picks at most one event that must flush younger work: a mispredicted branch, a memory-ordering violation, or a load that the memory system could not accept. From that instruction it builds one flush message for the commit stage. The message holds the sequence number at which flushing starts, the fetch address to restart from, whether the instruction itself is flushed too, and the branch outcome flags.

Inside one thread the oldest qualifying instruction wins, and every younger candidate in the same group is dropped. Each thread keeps a "blocked load already reported" flag, so a stalled load is not reported again until the memory side clears it. Two counters track honoured mispredictions, split by the direction that was predicted. Branch resolution and address disambiguation happen upstream; this block only consumes their flags.

Top module: `redirect_squash_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after reset is released with no stimulus, every `sq*` output and both counters read zero, and every thread's blocked-load flag is clear.
- R2: A qualifying instruction presented in cycle N produces its thread's message on the clock edge that ends cycle N. The message stays for exactly one cycle: with no qualifying instruction in cycle N+1, `sqValid` for that thread is 0 after the next edge. When `sqValid` is 0, all other message fields of that thread are 0.
- R3: Within one thread, only the qualifying instruction in the lowest-numbered slot (slot 0 is the oldest) produces the message. Qualifying instructions of that thread in higher slots are ignored for that cycle. The lock starts afresh every cycle.
- R4: Threads are independent. Each thread can get its own message in the same cycle, chosen only from the slots whose thread id matches it.
- R5: For one instruction the cause is chosen in this order: mispredict flag first, then ordering violation, then a blocked load whose thread has no outstanding unhandled report. If the highest present cause is a blocked load that is masked, the instruction does not qualify.
- R6: Branch cause: `sqSeq` is the instruction's sequence number, `sqPc` is its next PC, `sqInclSelf`=0 and `sqMispred`=1.
- R7: `sqTaken` is 1 only for a branch-cause message whose next PC differs from PC + `INST_BYTES` (4 by default), and is 0 for all other causes.
- R8: Ordering-violation cause: `sqSeq` is the instruction's sequence number, `sqPc` is its next PC, and `sqInclSelf`, `sqMispred` and `sqTaken` are all 0.
- R9: Blocked-load cause: `sqSeq` is the instruction's sequence number, `sqPc` is its own PC, `sqInclSelf`=1 and `sqMispred`=0. The thread's blocked flag is then set, and later blocked loads of that thread are ignored until `blkClear` for the thread is high. A `blkClear` in the same cycle as a new blocked load lets that load qualify.
- R10: Slots with `slotValid`=0, or with `slotSquashed`=1, never produce a message and never take a thread's lock.
- R11: `cntTakenWrong` increases by one for each thread message of branch cause whose instruction had `slotPredTaken`=1. `cntNotTakenWrong` does the same for `slotPredTaken`=0. Both update on the same edge as the message and wrap at 2^`CNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slotValid | input | GROUP | Slot holds a completing instruction |
| slotSquashed | input | GROUP | Instruction already flushed, ignore |
| slotTid | input | GROUP*TID_W | Thread id per slot |
| slotSeq | input | GROUP*SEQ_W | Sequence number per slot |
| slotPc | input | GROUP*PC_W | Instruction address per slot |
| slotNextPc | input | GROUP*PC_W | Resolved next address per slot |
| slotMispredict | input | GROUP | Branch was mispredicted |
| slotPredTaken | input | GROUP | Predictor said taken |
| slotOrderViol | input | GROUP | Memory ordering violation on this instruction |
| slotLoadBlk | input | GROUP | Load refused by memory system |
| blkClear | input | NUM_THREADS | Memory side lifts the blocked-load report mask |
| sqValid | output | NUM_THREADS | Flush message valid per thread |
| sqSeq | output | NUM_THREADS*SEQ_W | Flush start sequence number |
| sqPc | output | NUM_THREADS*PC_W | Restart fetch address |
| sqInclSelf | output | NUM_THREADS | Flush includes the instruction itself |
| sqMispred | output | NUM_THREADS | Message caused by branch mispredict |
| sqTaken | output | NUM_THREADS | Resolved branch was taken |
| cntTakenWrong | output | CNT_W | Honoured mispredicts predicted taken |
| cntNotTakenWrong | output | CNT_W | Honoured mispredicts predicted not taken |

## Verification
The hardest case to reach is the interaction between the per-cycle lock and the blocked-load mask that carries across cycles. A blocked load that loses to an older branch of the same thread must not set the mask. A masked load must not take the lock away from a younger violation in the same thread. A clear that arrives together with a new blocked load must let that load through. Directed cycles build each of these sequences on purpose, with several causes stacked on one thread and a second thread active at the same time. Long random runs then use skewed flag probabilities, so that lost and masked candidates happen often, and compare every cycle against a behavioural model.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_BRANCH  = 2'd1,
    CAUSE_ORDER   = 2'd2,
    CAUSE_BLOCKED = 2'd3
  } cause_e;

  // per-thread strobe bundle from control to datapath
  typedef struct packed {
    logic   fire;
    cause_e cause;
  } thrStrobe_t;
endpackage

// File: rtl/rsg_ctrl.sv
module rsg_ctrl
  import rsg_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int GROUP       = 4,
  parameter int TID_W       = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [GROUP-1:0]                slotValid,
  input  logic [GROUP-1:0]                slotSquashed,
  input  logic [GROUP*TID_W-1:0]          slotTid,
  input  logic [GROUP-1:0]                slotMispredict,
  input  logic [GROUP-1:0]                slotOrderViol,
  input  logic [GROUP-1:0]                slotLoadBlk,
  input  logic [NUM_THREADS-1:0]          blkClear,
  output thrStrobe_t [NUM_THREADS-1:0]    strobe,
  output logic [NUM_THREADS-1:0][GROUP-1:0] grant
);
  logic [NUM_THREADS-1:0] blkHandled;
  logic [NUM_THREADS-1:0] blkHandledEff;
  logic [TID_W-1:0]       tidOf [GROUP];
  cause_e                 slotCause [GROUP];

  // a clear in this cycle lifts the mask before decisions are taken
  assign blkHandledEff = blkHandled & ~blkClear;

  for (genvar g = 0; g < GROUP; g++) begin : g_slot
    assign tidOf[g] = slotTid[g*TID_W +: TID_W];

    always_comb begin
      slotCause[g] = CAUSE_NONE;
      if (slotValid[g] && !slotSquashed[g]) begin
        if (slotMispredict[g])
          slotCause[g] = CAUSE_BRANCH;
        else if (slotOrderViol[g])
          slotCause[g] = CAUSE_ORDER;
        else if (slotLoadBlk[g] && !blkHandledEff[tidOf[g]])
          slotCause[g] = CAUSE_BLOCKED;
      end
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    // oldest-first lock chain: first qualifying slot of this thread wins
    always_comb begin
      logic taken;
      taken     = 1'b0;
      strobe[t] = '0;
      grant[t]  = '0;
      for (int g = 0; g < GROUP; g++) begin
        if (!taken && slotCause[g] != CAUSE_NONE && tidOf[g] == TID_W'(t)) begin
          grant[t][g]     = 1'b1;
          strobe[t].fire  = 1'b1;
          strobe[t].cause = slotCause[g];
          taken           = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        blkHandled[t] <= 1'b0;
      else
        blkHandled[t] <= blkHandledEff[t] |
                         (strobe[t].fire && strobe[t].cause == CAUSE_BLOCKED);
    end

    // R9: a reported blocked load sets the mask for the next cycle
    p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe[t].fire && strobe[t].cause == CAUSE_BLOCKED) |=> blkHandled[t]);

    // R9: a masked thread never reports another blocked load
    p_no_refire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (blkHandled[t] && !blkClear[t]) |-> !(strobe[t].fire && strobe[t].cause == CAUSE_BLOCKED));
  end
endmodule

// File: rtl/rsg_datapath.sv
module rsg_datapath
  import rsg_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int GROUP       = 4,
  parameter int SEQ_W       = 16,
  parameter int PC_W        = 32,
  parameter int CNT_W       = 16,
  parameter int INST_BYTES  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [GROUP*SEQ_W-1:0]            slotSeq,
  input  logic [GROUP*PC_W-1:0]             slotPc,
  input  logic [GROUP*PC_W-1:0]             slotNextPc,
  input  logic [GROUP-1:0]                  slotPredTaken,
  input  thrStrobe_t [NUM_THREADS-1:0]      strobe,
  input  logic [NUM_THREADS-1:0][GROUP-1:0] grant,
  output logic [NUM_THREADS-1:0]            sqValid,
  output logic [NUM_THREADS*SEQ_W-1:0]      sqSeq,
  output logic [NUM_THREADS*PC_W-1:0]       sqPc,
  output logic [NUM_THREADS-1:0]            sqInclSelf,
  output logic [NUM_THREADS-1:0]            sqMispred,
  output logic [NUM_THREADS-1:0]            sqTaken,
  output logic [CNT_W-1:0]                  cntTakenWrong,
  output logic [CNT_W-1:0]                  cntNotTakenWrong
);
  logic [NUM_THREADS-1:0] brTaken, brNotTaken;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [SEQ_W-1:0] selSeq;
    logic [PC_W-1:0]  selPc, selNext;
    logic             selPredTaken;
    logic             isBranch, isBlocked;

    // one-hot grant selects the winning slot's fields
    always_comb begin
      selSeq       = '0;
      selPc        = '0;
      selNext      = '0;
      selPredTaken = 1'b0;
      for (int g = 0; g < GROUP; g++) begin
        if (grant[t][g]) begin
          selSeq       = selSeq  | slotSeq[g*SEQ_W +: SEQ_W];
          selPc        = selPc   | slotPc[g*PC_W +: PC_W];
          selNext      = selNext | slotNextPc[g*PC_W +: PC_W];
          selPredTaken = selPredTaken | slotPredTaken[g];
        end
      end
    end

    assign isBranch      = strobe[t].fire && strobe[t].cause == CAUSE_BRANCH;
    assign isBlocked     = strobe[t].fire && strobe[t].cause == CAUSE_BLOCKED;
    assign brTaken[t]    = isBranch && selPredTaken;
    assign brNotTaken[t] = isBranch && !selPredTaken;

    always_ff @(posedge clk) begin
      if (!rst_n || !strobe[t].fire) begin
        sqValid[t]                 <= 1'b0;
        sqSeq[t*SEQ_W +: SEQ_W]    <= '0;
        sqPc[t*PC_W +: PC_W]       <= '0;
        sqInclSelf[t]              <= 1'b0;
        sqMispred[t]               <= 1'b0;
        sqTaken[t]                 <= 1'b0;
      end else begin
        sqValid[t]                 <= 1'b1;
        sqSeq[t*SEQ_W +: SEQ_W]    <= selSeq;
        sqPc[t*PC_W +: PC_W]       <= isBlocked ? selPc : selNext;
        sqInclSelf[t]              <= isBlocked;
        sqMispred[t]               <= isBranch;
        sqTaken[t]                 <= isBranch && (selNext != selPc + PC_W'(INST_BYTES));
      end
    end

    // R7: taken only ever reported on a branch message
    p_taken_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sqTaken[t] |-> (sqMispred[t] && sqValid[t]));

    // R9: self-inclusive flush is never a mispredict message
    p_incl_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sqInclSelf[t] |-> (sqValid[t] && !sqMispred[t]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntTakenWrong    <= '0;
      cntNotTakenWrong <= '0;
    end else begin
      cntTakenWrong    <= cntTakenWrong + CNT_W'($countones(brTaken));
      cntNotTakenWrong <= cntNotTakenWrong + CNT_W'($countones(brNotTaken));
    end
  end

  // R11: each counter steps by at most one per thread per cycle
  p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(cntTakenWrong - $past(cntTakenWrong)) <= CNT_W'(NUM_THREADS));
  p_cnt_step_nt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(cntNotTakenWrong - $past(cntNotTakenWrong)) <= CNT_W'(NUM_THREADS));
endmodule

// File: rtl/redirect_squash_gen.sv
module redirect_squash_gen
  import rsg_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int GROUP       = 4,
  parameter int SEQ_W       = 16,
  parameter int PC_W        = 32,
  parameter int CNT_W       = 16,
  parameter int INST_BYTES  = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [GROUP-1:0]             slotValid,
  input  logic [GROUP-1:0]             slotSquashed,
  input  logic [GROUP*TID_W-1:0]       slotTid,
  input  logic [GROUP*SEQ_W-1:0]       slotSeq,
  input  logic [GROUP*PC_W-1:0]        slotPc,
  input  logic [GROUP*PC_W-1:0]        slotNextPc,
  input  logic [GROUP-1:0]             slotMispredict,
  input  logic [GROUP-1:0]             slotPredTaken,
  input  logic [GROUP-1:0]             slotOrderViol,
  input  logic [GROUP-1:0]             slotLoadBlk,
  input  logic [NUM_THREADS-1:0]       blkClear,
  output logic [NUM_THREADS-1:0]       sqValid,
  output logic [NUM_THREADS*SEQ_W-1:0] sqSeq,
  output logic [NUM_THREADS*PC_W-1:0]  sqPc,
  output logic [NUM_THREADS-1:0]       sqInclSelf,
  output logic [NUM_THREADS-1:0]       sqMispred,
  output logic [NUM_THREADS-1:0]       sqTaken,
  output logic [CNT_W-1:0]             cntTakenWrong,
  output logic [CNT_W-1:0]             cntNotTakenWrong
);
  thrStrobe_t [NUM_THREADS-1:0]      strobe;
  logic [NUM_THREADS-1:0][GROUP-1:0] grant;

  rsg_ctrl #(
    .NUM_THREADS(NUM_THREADS), .GROUP(GROUP), .TID_W(TID_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .slotValid(slotValid), .slotSquashed(slotSquashed), .slotTid(slotTid),
    .slotMispredict(slotMispredict), .slotOrderViol(slotOrderViol),
    .slotLoadBlk(slotLoadBlk), .blkClear(blkClear),
    .strobe(strobe), .grant(grant)
  );

  rsg_datapath #(
    .NUM_THREADS(NUM_THREADS), .GROUP(GROUP), .SEQ_W(SEQ_W), .PC_W(PC_W),
    .CNT_W(CNT_W), .INST_BYTES(INST_BYTES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n),
    .slotSeq(slotSeq), .slotPc(slotPc), .slotNextPc(slotNextPc),
    .slotPredTaken(slotPredTaken), .strobe(strobe), .grant(grant),
    .sqValid(sqValid), .sqSeq(sqSeq), .sqPc(sqPc), .sqInclSelf(sqInclSelf),
    .sqMispred(sqMispred), .sqTaken(sqTaken),
    .cntTakenWrong(cntTakenWrong), .cntNotTakenWrong(cntNotTakenWrong)
  );
endmodule

// File: tb/sim_redirect_squash_gen.sv
`timescale 1ns/100ps
module sim_redirect_squash_gen;
  localparam int T  = 2;
  localparam int G  = 4;
  localparam int SW = 16;
  localparam int PW = 32;
  localparam int CW = 16;
  localparam int TW = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [G-1:0]    slotValid, slotSquashed, slotMispredict, slotPredTaken, slotOrderViol, slotLoadBlk;
  logic [G*TW-1:0] slotTid;
  logic [G*SW-1:0] slotSeq;
  logic [G*PW-1:0] slotPc, slotNextPc;
  logic [T-1:0]    blkClear;
  logic [T-1:0]    sqValid, sqInclSelf, sqMispred, sqTaken;
  logic [T*SW-1:0] sqSeq;
  logic [T*PW-1:0] sqPc;
  logic [CW-1:0]   cntTakenWrong, cntNotTakenWrong;

  int tests = 0;
  int fails = 0;
  bit mHandled [T];
  int mTW = 0, mNTW = 0;

  always #2.5 clk = ~clk;

  redirect_squash_gen #(.NUM_THREADS(T), .GROUP(G), .SEQ_W(SW), .PC_W(PW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .slotValid(slotValid), .slotSquashed(slotSquashed), .slotTid(slotTid),
    .slotSeq(slotSeq), .slotPc(slotPc), .slotNextPc(slotNextPc),
    .slotMispredict(slotMispredict), .slotPredTaken(slotPredTaken),
    .slotOrderViol(slotOrderViol), .slotLoadBlk(slotLoadBlk), .blkClear(blkClear),
    .sqValid(sqValid), .sqSeq(sqSeq), .sqPc(sqPc), .sqInclSelf(sqInclSelf),
    .sqMispred(sqMispred), .sqTaken(sqTaken),
    .cntTakenWrong(cntTakenWrong), .cntNotTakenWrong(cntNotTakenWrong)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clearSlots();
    slotValid = '0; slotSquashed = '0; slotMispredict = '0; slotPredTaken = '0;
    slotOrderViol = '0; slotLoadBlk = '0; slotTid = '0; slotSeq = '0;
    slotPc = '0; slotNextPc = '0; blkClear = '0;
  endtask

  task automatic setSlot(int g, int tid, int seq, logic [31:0] pc, logic [31:0] npc,
                         bit mis = 0, bit pt = 0, bit ord = 0, bit blk = 0, bit sq = 0);
    slotValid[g] = 1'b1;
    slotTid[g] = tid[0];
    slotSeq[g*SW +: SW] = seq[15:0];
    slotPc[g*PW +: PW] = pc;
    slotNextPc[g*PW +: PW] = npc;
    slotMispredict[g] = mis; slotPredTaken[g] = pt;
    slotOrderViol[g] = ord; slotLoadBlk[g] = blk; slotSquashed[g] = sq;
  endtask

  // behavioural reference: compute expected message, advance edge, compare
  task automatic runCycle(string tag);
    bit eV [T]; bit eI [T]; bit eM [T]; bit eT [T];
    logic [31:0] eS [T]; logic [31:0] eP [T];
    bit nH [T];
    for (int t = 0; t < T; t++) begin
      bit lockd = 0;
      bit hEff = mHandled[t] && !blkClear[t];
      eV[t] = 0; eI[t] = 0; eM[t] = 0; eT[t] = 0; eS[t] = 0; eP[t] = 0;
      nH[t] = hEff;
      for (int g = 0; g < G; g++) begin
        logic [31:0] pc = slotPc[g*PW +: PW];
        logic [31:0] np = slotNextPc[g*PW +: PW];
        if (lockd || !slotValid[g] || slotSquashed[g] || int'(slotTid[g]) != t) continue;
        if (slotMispredict[g]) begin
          eV[t] = 1; eM[t] = 1; eP[t] = np; eT[t] = (np != pc + 32'd4);
          if (slotPredTaken[g]) mTW++; else mNTW++;
        end else if (slotOrderViol[g]) begin
          eV[t] = 1; eP[t] = np;
        end else if (slotLoadBlk[g] && !hEff) begin
          eV[t] = 1; eI[t] = 1; eP[t] = pc; nH[t] = 1;
        end else continue;
        eS[t] = {16'd0, slotSeq[g*SW +: SW]};
        lockd = 1;
      end
    end
    for (int t = 0; t < T; t++) mHandled[t] = nH[t];
    @(posedge clk); #1;
    for (int t = 0; t < T; t++) begin
      chk(tag, "R3 sqValid", sqValid[t], eV[t]);
      chk(tag, "R6 sqSeq", sqSeq[t*SW +: SW], eS[t]);
      chk(tag, "R8 sqPc", sqPc[t*PW +: PW], eP[t]);
      chk(tag, "R9 sqInclSelf", sqInclSelf[t], eI[t]);
      chk(tag, "R5 sqMispred", sqMispred[t], eM[t]);
      chk(tag, "R7 sqTaken", sqTaken[t], eT[t]);
    end
    chk(tag, "R11 cntTakenWrong", cntTakenWrong, mTW & 16'hffff);
    chk(tag, "R11 cntNotTakenWrong", cntNotTakenWrong, mNTW & 16'hffff);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clearSlots();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "sqValid", sqValid, 0);
    chk("R1", "cntTakenWrong", cntTakenWrong, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int t = 0; t < T; t++) mHandled[t] = 0;
    runCycle("R1 idle after reset");

    // R6 R7: branch, fall-through target, predicted taken
    @(negedge clk); clearSlots();
    setSlot(1, 0, 10, 32'h100, 32'h104, .mis(1), .pt(1));
    runCycle("R6 branch not taken");
    // R2: message lasts one cycle
    @(negedge clk); clearSlots();
    runCycle("R2 one-cycle pulse");
    // R7: taken branch
    @(negedge clk); clearSlots();
    setSlot(2, 1, 11, 32'h200, 32'h400, .mis(1), .pt(0));
    runCycle("R7 branch taken");
    // R3: oldest qualifying slot wins within thread
    @(negedge clk); clearSlots();
    setSlot(0, 0, 20, 32'h300, 32'h380, .ord(1));
    setSlot(2, 0, 21, 32'h310, 32'h500, .mis(1), .pt(1));
    runCycle("R3 oldest wins");
    // R4: two threads at once
    @(negedge clk); clearSlots();
    setSlot(0, 1, 30, 32'h600, 32'h604, .ord(1));
    setSlot(1, 0, 31, 32'h700, 32'h800, .mis(1));
    setSlot(3, 1, 32, 32'h610, 32'h900, .mis(1));
    runCycle("R4 threads independent");
    // R5: cause priority on one instruction, per thread
    @(negedge clk); clearSlots();
    setSlot(0, 0, 40, 32'ha00, 32'ha40, .mis(1), .pt(1), .ord(1), .blk(1));
    setSlot(1, 1, 41, 32'hb00, 32'hb04, .ord(1), .blk(1));
    runCycle("R5 priority");
    // R8: ordering violation alone
    @(negedge clk); clearSlots();
    setSlot(3, 0, 50, 32'hc00, 32'hc04, .ord(1));
    runCycle("R8 order violation");
    // R9: blocked load, then masked, then clear lets it through
    @(negedge clk); clearSlots();
    setSlot(1, 0, 60, 32'hd00, 32'hd04, .blk(1));
    runCycle("R9 blocked load");
    @(negedge clk); clearSlots();
    setSlot(0, 0, 61, 32'hd10, 32'hd14, .blk(1));
    setSlot(2, 0, 62, 32'hd20, 32'hd24, .ord(1));
    runCycle("R9 masked load, younger violation");
    @(negedge clk); clearSlots();
    blkClear[0] = 1'b1;
    setSlot(0, 0, 63, 32'hd30, 32'hd34, .blk(1));
    runCycle("R9 clear with new load");
    // R9: blocked load losing to older branch leaves mask as is
    @(negedge clk); clearSlots();
    blkClear = '1;
    setSlot(0, 1, 70, 32'he00, 32'he80, .mis(1));
    setSlot(1, 1, 71, 32'he10, 32'he14, .blk(1));
    runCycle("R9 load loses to branch");
    @(negedge clk); clearSlots();
    setSlot(2, 1, 72, 32'he20, 32'he24, .blk(1));
    runCycle("R9 thread1 load after loss");
    // R10: squashed and invalid slots ignored
    @(negedge clk); clearSlots();
    setSlot(0, 0, 80, 32'hf00, 32'hf80, .mis(1), .sq(1));
    setSlot(1, 0, 81, 32'hf10, 32'hf14, .ord(1));
    slotMispredict[2] = 1'b1;
    runCycle("R10 squashed ignored");

    // random traffic, R2 R3 R4 R5 R11
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); clearSlots();
      for (int g = 0; g < G; g++) begin
        if ($urandom_range(3) != 0) begin
          logic [31:0] pc = {$urandom} & 32'hfffffffc;
          logic [31:0] np = ($urandom_range(1) != 0) ? pc + 32'd4 : ({$urandom} & 32'hfffffffc);
          setSlot(g, int'($urandom_range(1)), int'($urandom_range(65535)), pc, np,
                  .mis($urandom_range(4) == 0), .pt($urandom_range(1) != 0),
                  .ord($urandom_range(4) == 0), .blk($urandom_range(2) == 0),
                  .sq($urandom_range(5) == 0));
        end
      end
      blkClear = T'($urandom_range(3) == 0 ? $urandom_range(3) : 0);
      runCycle("R3 R4 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule